// File: doc/BRIEF.md
# Time-Shared Error Diffusion Scheduler

This block turns a stream of per-pixel color values into pulse-density bits. For every pixel it keeps a running error word in an external single-port RAM. The RAM runs on a fast clock at exactly twice the pixel clock, so every pixel period holds two fast cycles. The first is a read slot, which fetches the stored error for a newer pixel. The second is a write slot, which stores the updated error of an older pixel. Per channel, the color is added to the stored error. The carry out of that sum is the output bit, and the low bits are written back to the same address as the new error.

The fast side has no direct view of the pixel clock. A register in the pixel domain flips on every pixel edge, and the fast side samples it through two flops. The XOR of those two flops marks the read slot. The fast side registers the RAM address, write enable and write data. It also drives a shift clock for an LED driver, and that clock pulses once per pixel in the write slot. The number of entries, the channel count and the channel width are parameters.

Top module: `pdm_err_sched`

## Requirements
- R1: Each pixel period holds two fast cycles: a read slot in which `ram_we` is 0, then a write slot. `ram_we` is never high on two consecutive fast cycles.
- R2: The first read slot after reset release begins at the second pixel edge out of reset and presents address 0. Each later read slot presents the next address. Read slots sit on `ram_addr` during the first fast cycle of each pixel period.
- R3: A write slot presents the address that was read two pixel periods earlier, with `ram_we` = 1. No write occurs during the pixel periods of the first two read slots.
- R4: The error for a read address is taken from `ram_rdata` one fast cycle after that address is on `ram_addr`.
- R5: For channel c, the color `color_in[c*W +: W]` and the stored error `ram_rdata[c*W +: W]` are added at W+1 bits. The carry goes to `pdm_out[c]` and the low W bits go to `ram_wdata[c*W +: W]`.
- R6: The color for a pixel must be on `color_in` during the pixel period that starts with that pixel's read slot. Its result appears on `pdm_out` at the second pixel edge after that period ends, and it holds for one period.
- R7: `led_clk` is 0 until the first valid write slot. After that it is 1 exactly during each valid write slot, so it rises while `pdm_out` is stable.
- R8: `pdm_out` stays 0 until the first valid result.
- R9: Read and write addresses wrap from N-1 to 0, and the write address keeps its two-entry lag across the wrap.
- R10: While the synchronous resets are high and right after release, `ram_we`, `led_clk` and `pdm_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | RAM clock, twice the pixel rate, rising edges aligned |
| rst_fast | input | 1 | Synchronous active-high reset, fast domain |
| clk_pix | input | 1 | Pixel clock |
| rst_pix | input | 1 | Synchronous active-high reset, pixel domain |
| color_in | input | CH*W | Color of the current pixel, channel c in bits c*W +: W |
| ram_rdata | input | CH*W | Read data from the RAM, one fast cycle latency |
| ram_addr | output | AW | RAM address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | CH*W | Updated error words |
| pdm_out | output | CH | Pulse-density bit per channel |
| led_clk | output | 1 | Shift clock for the LED driver |

## Verification
The embedded properties check the slot structure on every cycle. They cover the one-cycle read-slot pulse, write enables that never repeat back to back, a write address that trails the preceding read address by two modulo N, and a read pointer that wraps and stays two entries ahead of the write-back pointer. Only the bench scenarios can show that the arithmetic is correct. It checks the carry and residue for saturated, zero and random colors over several passes of the RAM. It also checks the exact pixel period in which a color's result appears, the idle write slots after reset, and the final RAM contents against a reference accumulator.

// File: rtl/pdm_sched_pkg.sv
package pdm_sched_pkg;

   // Address width for a table of v entries, never below one bit.
   function automatic int unsigned idx_width(int unsigned v);
      return (v <= 1) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/pdm_lane.sv
module pdm_lane #(
   parameter int W = 8
) (
   input  logic [W-1:0] color,
   input  logic [W-1:0] err,
   output logic         carry,
   output logic [W-1:0] resid
);

   // Sum widened by one bit: the top bit is the density pulse.
   assign {carry, resid} = {1'b0, color} + {1'b0, err};

endmodule

// File: rtl/pdm_phase_detect.sv
module pdm_phase_detect (
   input  logic clk_fast,
   input  logic rst_fast,
   input  logic pix_tgl,
   output logic rd_slot
);

   logic cap_a;
   logic cap_b;

   // Two flops follow the pixel-domain toggle. They differ for one fast
   // cycle after each pixel edge.
   always_ff @(posedge clk_fast) begin
      if (rst_fast) begin
         cap_a <= 1'b0;
         cap_b <= 1'b0;
      end else begin
         cap_a <= pix_tgl;
         cap_b <= cap_a;
      end
   end

   assign rd_slot = cap_a ^ cap_b;

   // R1: the read-slot mark lasts one fast cycle.
   p_slot_pulse_r1: assert property (@(posedge clk_fast) disable iff (rst_fast)
      rd_slot |=> !rd_slot);

endmodule

// File: rtl/pdm_pix_pipe.sv
module pdm_pix_pipe #(
   parameter int N  = 16,
   parameter int W  = 8,
   parameter int CH = 3,
   parameter int AW = 4
) (
   input  logic            clk_pix,
   input  logic            rst_pix,
   input  logic [CH*W-1:0] color_in,
   input  logic [CH*W-1:0] ram_rdata,
   output logic            pix_tgl,
   output logic [AW-1:0]   rd_ptr,
   output logic [AW-1:0]   wr_addr,
   output logic            wr_valid,
   output logic [CH*W-1:0] wr_data,
   output logic [CH-1:0]   pdm_out
);

   localparam int          DW   = CH * W;
   localparam logic [AW-1:0] LAST = AW'(N - 1);

   logic            tgl_q;
   logic            run_q;
   logic [AW-1:0]   ptr_q;
   logic [AW-1:0]   adr_s1, adr_s2, adr_s3;
   logic            vld_s1, vld_s2, vld_s3;
   logic [DW-1:0]   col_q;
   logic [DW-1:0]   err_q;
   logic [DW-1:0]   werr_q;
   logic [CH-1:0]   pdm_q;
   logic [DW-1:0]   resid_w;
   logic [CH-1:0]   carry_w;

   function automatic logic [AW-1:0] step(logic [AW-1:0] a);
      return (a == LAST) ? '0 : a + AW'(1);
   endfunction

   // One adder per channel.
   for (genvar c = 0; c < CH; c++) begin : g_lane
      pdm_lane #(.W(W)) u_lane (
         .color (col_q[c*W +: W]),
         .err   (err_q[c*W +: W]),
         .carry (carry_w[c]),
         .resid (resid_w[c*W +: W])
      );
   end

   always_ff @(posedge clk_pix) begin
      if (rst_pix) begin
         tgl_q  <= 1'b0;
         run_q  <= 1'b0;
         ptr_q  <= '0;
         adr_s1 <= '0;
         adr_s2 <= '0;
         adr_s3 <= '0;
         vld_s1 <= 1'b0;
         vld_s2 <= 1'b0;
         vld_s3 <= 1'b0;
         col_q  <= '0;
         err_q  <= '0;
         werr_q <= '0;
         pdm_q  <= '0;
      end else begin
         tgl_q  <= ~tgl_q;
         run_q  <= 1'b1;
         // Address 0 is held for the first period after release.
         ptr_q  <= run_q ? step(ptr_q) : '0;
         // Stage 1: the address was read in the slot at this edge.
         adr_s1 <= ptr_q;
         vld_s1 <= run_q;
         // Stage 2: read data is valid now, and the color for it arrives.
         adr_s2 <= adr_s1;
         vld_s2 <= vld_s1;
         col_q  <= color_in;
         err_q  <= ram_rdata;
         // Stage 3: the result is held for the write-back slot.
         adr_s3 <= adr_s2;
         vld_s3 <= vld_s2;
         werr_q <= resid_w;
         pdm_q  <= vld_s2 ? carry_w : '0;
      end
   end

   assign pix_tgl  = tgl_q;
   assign rd_ptr   = ptr_q;
   assign wr_addr  = adr_s3;
   assign wr_valid = vld_s3;
   assign wr_data  = werr_q;
   assign pdm_out  = pdm_q;

   // R2: the read pointer stays inside the table.
   p_ptr_range_r2: assert property (@(posedge clk_pix) disable iff (rst_pix)
      ptr_q <= LAST);

   // R9: the read pointer wraps from the last entry to 0.
   p_ptr_wrap_r9: assert property (@(posedge clk_pix) disable iff (rst_pix)
      (run_q && ptr_q == LAST) |=> (ptr_q == '0));

   // R3: the write-back address is three entries behind the pointer.
   p_lag_r3: assert property (@(posedge clk_pix) disable iff (rst_pix)
      vld_s3 |-> (((int'(adr_s3) + 3) % N) == int'(ptr_q)));

endmodule

// File: rtl/pdm_slot_mux.sv
module pdm_slot_mux #(
   parameter int N  = 16,
   parameter int AW = 4,
   parameter int DW = 24
) (
   input  logic          clk_fast,
   input  logic          rst_fast,
   input  logic          rd_slot,
   input  logic [AW-1:0] rd_ptr,
   input  logic [AW-1:0] wr_addr,
   input  logic          wr_valid,
   input  logic [DW-1:0] wr_data,
   output logic [AW-1:0] ram_addr,
   output logic          ram_we,
   output logic [DW-1:0] ram_wdata,
   output logic          led_clk
);

   always_ff @(posedge clk_fast) begin
      if (rst_fast) begin
         ram_addr  <= '0;
         ram_we    <= 1'b0;
         ram_wdata <= '0;
         led_clk   <= 1'b0;
      end else if (rd_slot) begin
         ram_addr  <= rd_ptr;
         ram_we    <= 1'b0;
         led_clk   <= 1'b0;
      end else begin
         ram_addr  <= wr_addr;
         ram_we    <= wr_valid;
         ram_wdata <= wr_data;
         led_clk   <= wr_valid;
      end
   end

   // R1: writes never occupy two fast cycles in a row.
   p_we_alt_r1: assert property (@(posedge clk_fast) disable iff (rst_fast)
      ram_we |=> !ram_we);

   // R3, R9: the write address trails the preceding read address by two,
   // modulo the table size.
   p_wr_trail_r3: assert property (@(posedge clk_fast) disable iff (rst_fast)
      ram_we |-> (((int'(ram_addr) + 2) % N) == int'($past(ram_addr))));

endmodule

// File: rtl/pdm_err_sched.sv
module pdm_err_sched #(
   parameter int N  = 16,
   parameter int W  = 8,
   parameter int CH = 3,
   localparam int AW = pdm_sched_pkg::idx_width(N),
   localparam int DW = CH * W
) (
   input  logic          clk_fast,
   input  logic          rst_fast,
   input  logic          clk_pix,
   input  logic          rst_pix,
   input  logic [DW-1:0] color_in,
   input  logic [DW-1:0] ram_rdata,
   output logic [AW-1:0] ram_addr,
   output logic          ram_we,
   output logic [DW-1:0] ram_wdata,
   output logic [CH-1:0] pdm_out,
   output logic          led_clk
);

   // A read must not reach an entry before its pending write-back lands.
   if (N < 3) begin : g_bad_depth
      $error("pdm_err_sched: N must be at least 3");
   end
   if (W < 1 || CH < 1) begin : g_bad_width
      $error("pdm_err_sched: W and CH must be positive");
   end

   logic          pix_tgl;
   logic          rd_slot;
   logic [AW-1:0] rd_ptr;
   logic [AW-1:0] wr_addr;
   logic          wr_valid;
   logic [DW-1:0] wr_data;

   pdm_pix_pipe #(.N(N), .W(W), .CH(CH), .AW(AW)) u_pipe (
      .clk_pix   (clk_pix),
      .rst_pix   (rst_pix),
      .color_in  (color_in),
      .ram_rdata (ram_rdata),
      .pix_tgl   (pix_tgl),
      .rd_ptr    (rd_ptr),
      .wr_addr   (wr_addr),
      .wr_valid  (wr_valid),
      .wr_data   (wr_data),
      .pdm_out   (pdm_out)
   );

   pdm_phase_detect u_phase (
      .clk_fast (clk_fast),
      .rst_fast (rst_fast),
      .pix_tgl  (pix_tgl),
      .rd_slot  (rd_slot)
   );

   pdm_slot_mux #(.N(N), .AW(AW), .DW(DW)) u_mux (
      .clk_fast  (clk_fast),
      .rst_fast  (rst_fast),
      .rd_slot   (rd_slot),
      .rd_ptr    (rd_ptr),
      .wr_addr   (wr_addr),
      .wr_valid  (wr_valid),
      .wr_data   (wr_data),
      .ram_addr  (ram_addr),
      .ram_we    (ram_we),
      .ram_wdata (ram_wdata),
      .led_clk   (led_clk)
   );

endmodule

// File: tb/test_pdm_err_sched.sv
module test_pdm_err_sched;

   localparam int N  = 16;
   localparam int W  = 8;
   localparam int CH = 3;
   localparam int AW = 4;
   localparam int DW = CH * W;
   localparam int P  = 80;
   localparam int NT = P + 4;

   logic          clk_fast = 1'b0;
   logic          clk_pix  = 1'b0;
   logic          rst_fast = 1'b1;
   logic          rst_pix  = 1'b1;
   logic [DW-1:0] color_in = '0;
   logic [DW-1:0] ram_rdata;
   logic [AW-1:0] ram_addr;
   logic          ram_we;
   logic [DW-1:0] ram_wdata;
   logic [CH-1:0] pdm_out;
   logic          led_clk;

   logic [DW-1:0] mem     [N];
   logic [DW-1:0] ref_mem [N];
   logic [DW-1:0] exp_err [NT];
   logic [CH-1:0] exp_bit [NT];

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   pdm_err_sched #(.N(N), .W(W), .CH(CH)) i_pdm_err_sched (
      .clk_fast  (clk_fast),
      .rst_fast  (rst_fast),
      .clk_pix   (clk_pix),
      .rst_pix   (rst_pix),
      .color_in  (color_in),
      .ram_rdata (ram_rdata),
      .ram_addr  (ram_addr),
      .ram_we    (ram_we),
      .ram_wdata (ram_wdata),
      .pdm_out   (pdm_out),
      .led_clk   (led_clk)
   );

   // 125 MHz fast clock; the pixel clock runs at half that rate, rising together.
   initial forever #4 clk_fast = ~clk_fast;
   initial forever begin
      #4 clk_pix = 1'b1;
      #8 clk_pix = 1'b0;
      #4;
   end

   // Behavioral single-port RAM with one-cycle read latency.
   always @(posedge clk_fast) begin
      if (rst_fast) begin
         for (int i = 0; i < N; i++) mem[i] <= '0;
      end else if (ram_we) begin
         mem[ram_addr] <= ram_wdata;
      end
      ram_rdata <= mem[ram_addr];
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pick_color(int m);
      if (m < 32)      return '1;
      else if (m < 48) return '0;
      else if (m < P)  return DW'($urandom);
      else             return '0;
   endfunction

   initial begin
      void'($urandom(32'd7321));
      for (int i = 0; i < N; i++) ref_mem[i] = '0;
      repeat (4) @(posedge clk_pix);
      #2;
      // R10: reset state
      chk("R10 we in reset", 64'(ram_we), 64'd0);
      chk("R10 led_clk in reset", 64'(led_clk), 64'd0);
      chk("R10 pdm_out in reset", 64'(pdm_out), 64'd0);
      rst_fast = 1'b0;
      rst_pix  = 1'b0;

      for (int n = 0; n < NT; n++) begin
         @(posedge clk_pix);
         #2;
         if (n >= 1) begin
            int m;
            int a;
            logic [DW-1:0] col;
            logic [DW-1:0] nerr;
            logic [CH-1:0] nbit;
            m = n - 1;
            a = m % N;
            col = pick_color(m);
            color_in = col;
            for (int c = 0; c < CH; c++) begin
               logic [W:0] s;
               s = {1'b0, col[c*W +: W]} + {1'b0, ref_mem[a][c*W +: W]};
               nbit[c] = s[W];
               nerr[c*W +: W] = s[W-1:0];
            end
            ref_mem[a] = nerr;
            exp_err[m] = nerr;
            exp_bit[m] = nbit;
            // R2, R9: read slot address
            chk("R2 read address", 64'(ram_addr), 64'(m % N));
            chk("R1 no write in read slot", 64'(ram_we), 64'd0);
            chk("R7 led_clk low in read slot", 64'(led_clk), 64'd0);
         end
         if (n >= 3) chk("R6 pdm_out for pixel", 64'(pdm_out), 64'(exp_bit[n-3]));
         else        chk("R8 pdm_out idle before first result", 64'(pdm_out), 64'd0);

         #8;
         if (n >= 3) begin
            chk("R3 write enable in write slot", 64'(ram_we), 64'd1);
            chk("R9 write address lag", 64'(ram_addr), 64'((n - 3) % N));
            chk("R5 write data (R4 read latency)", 64'(ram_wdata), 64'(exp_err[n-3]));
            chk("R7 led_clk pulse", 64'(led_clk), 64'd1);
            chk("R7 pdm_out stable at led_clk", 64'(pdm_out), 64'(exp_bit[n-3]));
         end else begin
            chk("R3 no write while filling", 64'(ram_we), 64'd0);
            chk("R7 led_clk low while filling", 64'(led_clk), 64'd0);
         end
      end

      color_in = '0;
      repeat (6) @(posedge clk_pix);
      #2;
      for (int i = 0; i < N; i++)
         chk("R5 stored error (R4)", 64'(mem[i]), 64'(ref_mem[i]));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule